// File: doc/BRIEF.md
# Parity-Compacted Multiple-Input Signature Register

This block collects the responses of a scan-based self-test that shifts out of nine parallel scan chains at once. Each shift cycle delivers one bit per chain. A parity tree first reduces those bits to one bit, or to a few bits when configured for more than one output group. A multiple-input signature register then folds the reduced bits over time into a signature. Shrinking the data in space before compacting it in time means one short register can absorb all chains in every shift cycle. The test time stays set by chain length, and the cost is some extra risk of error masking.

A test session starts with a synchronous clear. Responses are then shifted in with the valid strobe high. At the end, a done strobe compares the running signature with an expected value supplied from outside. The result is latched as a pass flag.

Top module: `parity_misr`

## Requirements
- R1: An asynchronous active-low reset drives the signature and the pass flag to zero.
- R2: With one output group (default), the injected bit is the XOR of all chain bits. Two input words with equal parity therefore have the same effect on the signature.
- R3: On a valid cycle the signature s becomes t. Here t[0] = s[W-1] ^ p[0], and for i >= 1, t[i] = s[i-1] ^ (POLY[i] & s[W-1]) ^ p[i], with p[i] = 0 for i >= number of groups. The default W is 16 and the default POLY is 16'hA011 (x^16+x^15+x^13+x^4+1).
- R4: A synchronous clear zeroes the signature and the pass flag. It takes priority over a valid strobe and a done strobe in the same cycle.
- R5: A cycle with the valid strobe low and no clear leaves the signature unchanged.
- R6: A done strobe registers the pass flag as the equality of expected with the signature value held before that clock edge. This holds even if a shift happens in the same cycle.
- R7: Between done strobes the pass flag keeps its value until a clear.
- R8: With the default polynomial and zero input, the signature seeded at 1 first returns to 1 after exactly 65535 shifts.
- R9: With G output groups, chain c feeds group c mod G, and group g's parity is injected at stage g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous session clear |
| shift_vld | input | 1 | A shift cycle delivers chain bits |
| scan_out | input | N_CHAINS | One response bit per chain |
| done | input | 1 | Compare request |
| expected | input | SIG_W | Expected final signature |
| signature | output | SIG_W | Running signature |
| pass | output | 1 | Latched comparison result |

## Verification
The embedded assertions check on every cycle that clear zeroes the state, that idle cycles and non-done cycles hold it, that the pass flag follows the compare made at the done strobe, and that an all-zero state with all-zero input stays zero. A single-group step from zero with odd parity is also checked to land on 1. Only the bench scenarios can show that the full recurrence matches the polynomial over long random runs, and that parity-equal words are interchangeable. They also show that the default polynomial has maximal period, and that three-group wiring sends each chain to the correct stage.

// File: rtl/parity_misr.sv
`timescale 1ns/1ps
module parity_misr #(
  parameter int N_CHAINS = 9,
  parameter int SIG_W    = 16,
  parameter int N_OUT    = 1,
  parameter logic [SIG_W-1:0] POLY = 'hA011
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                shift_vld,
  input  logic [N_CHAINS-1:0] scan_out,
  input  logic                done,
  input  logic [SIG_W-1:0]    expected,
  output logic [SIG_W-1:0]    signature,
  output logic                pass
);

  function automatic logic [N_CHAINS-1:0] grp_mask(input int g);
    logic [N_CHAINS-1:0] m;
    m = '0;
    for (int c = 0; c < N_CHAINS; c++)
      if (c % N_OUT == g) m[c] = 1'b1;
    return m;
  endfunction

  logic [N_OUT-1:0] par;
  logic [SIG_W-1:0] nxt;

  for (genvar g = 0; g < N_OUT; g++) begin : g_grp
    localparam logic [N_CHAINS-1:0] MASK = grp_mask(g);
    assign par[g] = ^(scan_out & MASK);
  end

  assign nxt = {signature[SIG_W-2:0], 1'b0}
             ^ (signature[SIG_W-1] ? POLY : '0)
             ^ SIG_W'(par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      signature <= '0;
      pass      <= 1'b0;
    end else if (clr) begin
      signature <= '0;
      pass      <= 1'b0;
    end else begin
      if (shift_vld) signature <= nxt;
      if (done)      pass      <= (signature == expected);
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (signature == '0) && !pass); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !shift_vld |=> $stable(signature)); // R5
  AST_DONE_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && done |=> pass == ($past(signature) == $past(expected))); // R6
  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !done |=> $stable(pass)); // R7
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && shift_vld && signature == '0 && scan_out == '0 |=> signature == '0); // R3
  AST_ODD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (N_OUT == 1) && !clr && shift_vld && signature == '0 && ($countones(scan_out) % 2 == 1)
    |=> signature == SIG_W'(1)); // R2

endmodule

// File: tb/sim_parity_misr.sv
`timescale 1ns/1ps
module sim_parity_misr;
  localparam int NC = 9;
  localparam int W  = 16;
  localparam logic [W-1:0] PL = 16'hA011;

  logic clk = 0, rst_n = 0, clr = 0, shift_vld = 0, done = 0;
  logic [NC-1:0] scan_out = '0;
  logic [W-1:0]  expected = '0;
  logic [W-1:0]  sig0, sig1;
  logic          pass0, pass1;
  int checks = 0, errors = 0;
  logic [W-1:0] m0 = '0, m1 = '0;
  logic         mp0 = 0, mp1 = 0;

  always #2.5 clk = ~clk;

  parity_misr u0 (.clk, .rst_n, .clr, .shift_vld, .scan_out, .done, .expected,
                  .signature(sig0), .pass(pass0));
  parity_misr #(.N_OUT(3)) u1 (.clk, .rst_n, .clr, .shift_vld, .scan_out, .done,
                  .expected, .signature(sig1), .pass(pass1));

  function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [NC-1:0] d,
                                         input int g);
    logic [W-1:0] t;
    logic [W-1:0] inj = '0;
    for (int c = 0; c < NC; c++) inj[c % g] ^= d[c];
    t[0] = s[W-1] ^ inj[0];
    for (int i = 1; i < W; i++) t[i] = s[i-1] ^ (PL[i] & s[W-1]) ^ inj[i];
    return t;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic cyc(input logic c, input logic v, input logic [NC-1:0] d,
                     input logic dn, input logic [W-1:0] ex);
    clr = c; shift_vld = v; scan_out = d; done = dn; expected = ex;
    if (c) begin m0 = '0; m1 = '0; mp0 = 0; mp1 = 0; end
    else begin
      if (dn) begin mp0 = (m0 == ex); mp1 = (m1 == ex); end
      if (v) begin m0 = model(m0, d, 1); m1 = model(m1, d, 3); end
    end
    @(posedge clk); #1;
    chk("R3 sig u0", sig0, m0);
    chk("R9 sig u1", sig1, m1);
    chk("R6/R7 pass u0", W'(pass0), W'(mp0));
    chk("R6/R7 pass u1", W'(pass1), W'(mp1));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] snap;
    int period;
    void'($urandom(32'h5eed1234));
    #3;
    chk("R1 reset sig", sig0, '0);
    chk("R1 reset pass", W'(pass0), '0);
    #5 rst_n = 1;
    @(posedge clk); #1;

    // R2: odd parity from zero gives 1, even parity gives 0
    cyc(1, 0, '0, 0, '0);
    cyc(0, 1, 9'b100000000, 0, '0);
    chk("R2 odd parity seed", sig0, 16'h0001);
    cyc(1, 0, '0, 0, '0);
    cyc(0, 1, 9'b110000000, 0, '0);
    chk("R2 even parity", sig0, 16'h0000);
    // R9: chain 4 -> group 1 -> stage 1 for three groups
    cyc(1, 0, '0, 0, '0);
    cyc(0, 1, 9'b000010000, 0, '0);
    chk("R9 chain4 stage1", sig1, 16'h0002);

    // R2: parity-equal words lead to the same signature
    cyc(1, 0, '0, 0, '0);
    for (int k = 0; k < 20; k++) cyc(0, 1, 9'(k * 37), 0, '0);
    snap = sig0;
    cyc(1, 0, '0, 0, '0);
    for (int k = 0; k < 20; k++)
      cyc(0, 1, (^(9'(k * 37))) ? 9'b000000001 : 9'b000000000, 0, '0);
    chk("R2 parity equivalence", sig0, snap);

    // random session, R5 idle cycles mixed in
    cyc(1, 0, '0, 0, '0);
    for (int k = 0; k < 3000; k++)
      cyc(0, ($urandom % 10) < 7, NC'($urandom), 0, '0);
    // R6 match, then R7 hold while shifting
    cyc(0, 1, NC'($urandom), 1, m0);
    chk("R6 match pass", W'(pass0), 16'h0001);
    for (int k = 0; k < 10; k++) cyc(0, 1, NC'($urandom), 0, '0);
    chk("R7 pass held", W'(pass0), 16'h0001);
    cyc(0, 0, '0, 1, ~m0);
    chk("R6 mismatch", W'(pass0), 16'h0000);
    // R4 clear wins over shift and done
    cyc(1, 1, 9'h1FF, 1, '0);
    chk("R4 clear priority sig", sig0, '0);
    chk("R4 clear priority pass", W'(pass0), '0);
    // random mix with occasional done and clear
    for (int k = 0; k < 4000; k++) begin
      logic dn = ($urandom % 50) == 0;
      cyc(($urandom % 500) == 0, ($urandom % 4) != 0, NC'($urandom), dn,
          (($urandom % 2) == 0) ? m0 : W'($urandom));
    end

    // R8 period of the default polynomial
    cyc(1, 0, '0, 0, '0);
    cyc(0, 1, 9'b000000001, 0, '0);
    period = 0;
    clr = 0; shift_vld = 1; scan_out = '0; done = 0;
    for (int k = 0; k < 70000; k++) begin
      @(posedge clk); #1;
      period++;
      if (sig0 == 16'h0001) break;
    end
    chk("R8 period", W'(period), 16'hFFFF);
    shift_vld = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule